// File: doc/BRIEF.md
# Accumulator Processor Core with Opcode Decoder

This block is a small accumulator machine that fetches, decodes and executes instructions held in a word-addressed RAM. Program and data share that RAM. Each word holds a 4-bit opcode in its top bits and an operand address in its low bits. A combinational decoder turns the opcode into five control strobes. A three-phase sequencer applies those strobes to an accumulator, a zero flag, a carry flag and a program counter.

The RAM is filled through a preload port while the core is held in reset. After reset is released, the program runs. Each OUT instruction emits the accumulator on the output bus with a one-cycle valid strobe. A halt instruction raises a status flag that stays high until the next reset.

Top module: `acc_core`

## Requirements
- R1: Synchronous reset (`rst` high) sets the program counter, accumulator, zero flag and carry flag to zero, and drives `halted`, `out_valid` and `out_data` low. A program whose first instruction is OUT therefore emits 0x00.
- R2: Every instruction takes exactly three clocks (fetch, decode, execute). When no branch is taken, the k-th instruction executed (k counted from 1) completes on the 3k-th rising edge after reset is released.
- R3: The opcode is word bits [DATA_W-1:DATA_W-4] and the operand address is bits [ADDR_W-1:0]. The codes are:
  - LDA=0x0: loads RAM[addr] into A and leaves both flags unchanged.
  - ADD=0x1
  - SUB=0x2
  - STA=0x3
  - JMP=0x4
  - JZ=0x5
  - JC=0x6
  - OUT=0xE
  - HLT=0xF
- R4: ADD sets A to A+RAM[addr] and SUB sets A to A-RAM[addr], both modulo 2^DATA_W. Carry is the adder carry-out for ADD and not-borrow (A >= operand) for SUB. Zero is set when the result is 0. No other instruction changes either flag.
- R5: STA writes A into RAM[addr], and a later LDA of that address returns the stored value.
- R6: JMP always loads the program counter with addr.
- R7: JZ branches only when the zero flag is set, and JC branches only when the carry flag is set. Otherwise execution falls through to the next word.
- R8: OUT drives A on `out_data` and raises `out_valid` for exactly one clock, on the execute edge of that instruction.
- R9: HLT sets `halted`, which stays high until reset. No output appears after it, and the accumulator and program counter hold their values.
- R10: The unused opcodes 0x7 to 0xD execute as no-ops. They change neither A nor the flags, and execution continues at the next word.
- R11: While `rst` is high, a cycle with `pre_we` high writes `pre_data` into RAM[`pre_addr`]. Execution starts from that image at address 0.
- R12: The decoder derives its strobes from the opcode alone:
  - ALU enable is set for ADD and SUB only.
  - RAM read is set for LDA, ADD and SUB.
  - RAM write is set for STA only.
  - PC load is set for JMP, JZ and JC.
  - Output enable is set for OUT only.
  - RAM read and RAM write are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | ADDR_W | Preload RAM address |
| pre_data | input | DATA_W | Preload RAM word |
| out_data | output | DATA_W | Accumulator value captured by OUT |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |
| halted | output | 1 | High once HLT has executed |

## Verification
The assertions assume that the RAM image is loaded only while reset is held, so that no preload write races with a STA of the running program. The bench keeps `pre_we` low whenever `rst` is low. The assertions also assume that the instruction register is steady during the execute phase. This holds because only the fetch phase writes it. The stimulus consists of hand-built programs whose expected outputs and output cycles are worked out from the requirements. These programs take every branch both ways, set and clear each flag, include an unused opcode and end in HLT.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_LDA = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_STA = 4'h3,
    OP_JMP = 4'h4,
    OP_JZ  = 4'h5,
    OP_JC  = 4'h6,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } opcode_e;

  typedef struct packed {
    logic alu_en;
    logic mem_rd;
    logic mem_wr;
    logic pc_ld;
    logic out_en;
  } strobes_t;

  typedef enum logic [1:0] {
    PH_FETCH,
    PH_DECODE,
    PH_EXEC,
    PH_HALT
  } phase_e;
endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output strobes_t         stb,
  output logic             is_jmp,
  output logic             is_jz,
  output logic             is_jc,
  output logic             is_sub,
  output logic             is_halt
);
  always_comb begin
    stb = '0;
    unique case (opc)
      OP_LDA:  stb.mem_rd = 1'b1;
      OP_ADD,
      OP_SUB:  begin stb.alu_en = 1'b1; stb.mem_rd = 1'b1; end
      OP_STA:  stb.mem_wr = 1'b1;
      OP_JMP,
      OP_JZ,
      OP_JC:   stb.pc_ld = 1'b1;
      OP_OUT:  stb.out_en = 1'b1;
      default: stb = '0;
    endcase
  end

  assign is_jmp  = (opc == OP_JMP);
  assign is_jz   = (opc == OP_JZ);
  assign is_jc   = (opc == OP_JC);
  assign is_sub  = (opc == OP_SUB);
  assign is_halt = (opc == OP_HLT);
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero
);
  // Extended sum: subtraction is a + ~b + 1, so bit W is not-borrow.
  function automatic logic [W:0] ext_sum(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic         neg);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, (neg ? ~y : y)} + {{W{1'b0}}, neg};
    return t;
  endfunction

  logic [W:0] sum_w;
  assign sum_w = ext_sum(a, b, sub);
  assign res   = sum_w[W-1:0];
  assign carry = sum_w[W];
  assign zero  = (sum_w[W-1:0] == '0);
endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Preload has priority over a core store.
  always_ff @(posedge clk) begin
    if (pre_we)     mem[pre_addr] <= pre_data;
    else if (wr_en) mem[wr_addr]  <= wr_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  localparam int OPC_LSB = DATA_W - OPC_W;

  phase_e            phase;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, opnd, acc;
  logic              zf, cf;

  // Named internal events for the assertions
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] tgt;
  strobes_t          stb;
  logic              is_jmp, is_jz, is_jc, is_sub, is_halt;
  logic              exec_now, take_branch, store_now;
  logic [DATA_W-1:0] instr_word, opnd_word, alu_res;
  logic              alu_c, alu_z;

  assign opc = ir[DATA_W-1:OPC_LSB];
  assign tgt = ir[ADDR_W-1:0];

  acc_decoder u_dec (
    .opc     (opc),
    .stb     (stb),
    .is_jmp  (is_jmp),
    .is_jz   (is_jz),
    .is_jc   (is_jc),
    .is_sub  (is_sub),
    .is_halt (is_halt)
  );

  assign exec_now    = (phase == PH_EXEC);
  assign take_branch = stb.pc_ld & (is_jmp | (is_jz & zf) | (is_jc & cf));
  assign store_now   = exec_now & stb.mem_wr;

  acc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk      (clk),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .wr_en    (store_now),
    .wr_addr  (tgt),
    .wr_data  (acc),
    .ra_addr  (pc),
    .ra_data  (instr_word),
    .rb_addr  (tgt),
    .rb_data  (opnd_word)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .a     (acc),
    .b     (opnd),
    .sub   (is_sub),
    .res   (alu_res),
    .carry (alu_c),
    .zero  (alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_FETCH;
      pc        <= '0;
      ir        <= '0;
      opnd      <= '0;
      acc       <= '0;
      zf        <= 1'b0;
      cf        <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      halted    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (phase)
        PH_FETCH: begin
          ir    <= instr_word;
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          opnd  <= opnd_word;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (is_halt) begin
            halted <= 1'b1;
            phase  <= PH_HALT;
          end else begin
            if (stb.alu_en) begin
              acc <= alu_res;
              zf  <= alu_z;
              cf  <= alu_c;
            end else if (stb.mem_rd) begin
              acc <= opnd;
            end
            if (stb.out_en) begin
              out_data  <= acc;
              out_valid <= 1'b1;
            end
            pc    <= take_branch ? tgt : pc + 1'b1;
            phase <= PH_FETCH;
          end
        end
        default: phase <= PH_HALT;
      endcase
    end
  end

  // Assertions guarding the decoder and sequencer
  assert_rw_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(stb.mem_rd && stb.mem_wr));

  assert_alu_reads_R12: assert property (@(posedge clk) disable iff (rst)
    stb.alu_en |-> stb.mem_rd);

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (phase == PH_DECODE));

  assert_decode_step_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE) |=> (phase == PH_EXEC));

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_now && !stb.alu_en) |=> ($stable(zf) && $stable(cf)));

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_now && !take_branch && !is_halt) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc) && $stable(pc) && !out_valid));
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          halted;

  acc_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk       (clk),
    .rst       (rst),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .halted    (halted)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wd     = 0;
  bit done   = 1'b0;

  logic [DW-1:0] img [16];
  logic [DW-1:0] q_val[$];
  int            q_cyc[$];

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each output is checked against the next queued item
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (q_val.size() == 0) begin
        check(1'b0, "R9 unexpected output", int'(out_data), -1);
      end else begin
        logic [DW-1:0] ev;
        int ec;
        ev = q_val.pop_front();
        ec = q_cyc.pop_front();
        check(out_data == ev, "R8 output value", int'(out_data), int'(ev));
        check(cyc == ec, "R2 output cycle", cyc, ec);
      end
    end
  end

  task automatic expect_out(input logic [DW-1:0] v, input int c);
    q_val.push_back(v);
    q_cyc.push_back(c);
  endtask

  function automatic logic [DW-1:0] w(input logic [3:0] op, input logic [3:0] a);
    return {op, a};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = '0;
    q_val.delete();
    q_cyc.delete();
  endtask

  // R11: preload under reset, then release at a falling edge
  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pre_we   = 1'b1;
      pre_addr = AW'(i);
      pre_data = img[i];
    end
    @(negedge clk);
    pre_we = 1'b0;
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
    check(out_data == '0, "R1 out_data in reset", int'(out_data), 0);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_prog(input int halt_cyc, input string tag);
    wait_cyc(halt_cyc - 1);
    check(halted == 1'b0, {tag, " R9 halted early"}, int'(halted), 0);
    wait_cyc(halt_cyc);
    check(halted == 1'b1, {tag, " R9 halted at HLT"}, int'(halted), 1);
    wait_cyc(halt_cyc + 30);
    check(halted == 1'b1, {tag, " R9 halted sticky"}, int'(halted), 1);
    check(q_val.size() == 0, {tag, " R7 missing outputs"}, q_val.size(), 0);
  endtask

  initial begin
    // Program A: R3 LDA, R4 ADD/SUB, R5 STA, R8 OUT, R9 HLT
    clear_img();
    img[0]  = w(4'h0, 4'd10);  // LDA 10 -> 5
    img[1]  = w(4'h1, 4'd11);  // ADD 11 -> 12
    img[2]  = w(4'hE, 4'd0);   // OUT
    img[3]  = w(4'h3, 4'd14);  // STA 14
    img[4]  = w(4'h2, 4'd12);  // SUB 12 -> 9
    img[5]  = w(4'hE, 4'd0);   // OUT
    img[6]  = w(4'h0, 4'd14);  // LDA 14 -> 12
    img[7]  = w(4'hE, 4'd0);   // OUT
    img[8]  = w(4'hF, 4'd0);   // HLT
    img[9]  = w(4'hE, 4'd0);   // OUT, never reached
    img[10] = 8'h05;
    img[11] = 8'h07;
    img[12] = 8'h03;
    expect_out(8'h0C, 9);   // R4
    expect_out(8'h09, 18);  // R4
    expect_out(8'h0C, 24);  // R5
    load_and_start();
    finish_prog(27, "progA");

    // Program B: R7 JZ/JC taken and not taken, R4 carry/borrow flags
    clear_img();
    img[0]  = w(4'h0, 4'd14);  // LDA 14 -> FF
    img[1]  = w(4'h1, 4'd13);  // ADD 13 -> 00, C=1 Z=1
    img[2]  = w(4'h6, 4'd5);   // JC 5 taken
    img[3]  = w(4'hE, 4'd0);
    img[4]  = w(4'hF, 4'd0);
    img[5]  = w(4'hE, 4'd0);   // OUT 00
    img[6]  = w(4'h5, 4'd8);   // JZ 8 taken
    img[7]  = w(4'hF, 4'd0);
    img[8]  = w(4'h2, 4'd13);  // SUB 13 -> FF, C=0 Z=0
    img[9]  = w(4'hE, 4'd0);   // OUT FF
    img[10] = w(4'h5, 4'd3);   // JZ not taken
    img[11] = w(4'h6, 4'd3);   // JC not taken
    img[12] = w(4'hF, 4'd0);   // HLT
    img[13] = 8'h01;
    img[14] = 8'hFF;
    expect_out(8'h00, 12);  // R7 JC taken on carry-out
    expect_out(8'hFF, 21);  // R7 JZ taken; R4 SUB wrap
    load_and_start();
    finish_prog(30, "progB");

    // Program C: R6 JMP, R10 unused opcode, R3 LDA keeps flags
    clear_img();
    img[0]  = w(4'h0, 4'd15);  // LDA 15 -> 80
    img[1]  = w(4'h1, 4'd14);  // ADD 14 -> 00, C=1 Z=1
    img[2]  = w(4'h0, 4'd15);  // LDA 15 -> 80, flags kept
    img[3]  = w(4'h7, 4'd5);   // unused opcode: no-op
    img[4]  = w(4'h5, 4'd6);   // JZ 6 taken only if Z survived
    img[5]  = w(4'hF, 4'd0);
    img[6]  = w(4'hE, 4'd0);   // OUT 80
    img[7]  = w(4'h4, 4'd9);   // JMP 9
    img[8]  = w(4'hE, 4'd0);   // skipped
    img[9]  = w(4'h2, 4'd15);  // SUB 15 -> 00, C=1
    img[10] = w(4'h6, 4'd12);  // JC 12 taken
    img[11] = w(4'hF, 4'd0);
    img[12] = w(4'hE, 4'd0);   // OUT 00
    img[13] = w(4'hF, 4'd0);
    img[14] = 8'h80;
    img[15] = 8'h80;
    expect_out(8'h80, 18);  // R10, R3
    expect_out(8'h00, 30);  // R6
    load_and_start();
    finish_prog(33, "progC");

    // Program D: R1 accumulator and flags cleared by reset (after a halt)
    clear_img();
    img[0]  = w(4'hE, 4'd0);   // OUT -> 00
    img[1]  = w(4'h5, 4'd5);   // JZ must fall through
    img[2]  = w(4'h6, 4'd5);   // JC must fall through
    img[3]  = w(4'h0, 4'd15);  // LDA 15 -> 42
    img[4]  = w(4'hE, 4'd0);   // OUT 42
    img[5]  = w(4'hF, 4'd0);
    img[15] = 8'h42;
    expect_out(8'h00, 3);   // R1
    expect_out(8'h42, 15);  // R1 flags clear
    load_and_start();
    finish_prog(18, "progD");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule